// File: doc/BRIEF.md
# Debounced Threshold Flag Generator

This block watches a stream of filtered samples from one channel and drives a set of flags, one per lane. Each lane compares every valid sample against its own threshold. The comparison direction is set per lane: over-threshold or under-threshold. A lane's flag is a glitch-filtered view of that comparison. It rises only after a run of consecutive qualifying samples, and it falls only after a separate run of consecutive non-qualifying samples. The two run lengths are programmed independently.

All lanes share the sample stream, so several flags with different thresholds, directions and run lengths can watch the same channel. Each lane keeps a single run counter. While the flag is low, the counter tallies qualifying samples. While the flag is high, it tallies failing samples. It is cleared whenever a sample breaks the run and whenever the flag changes state.

Top module: `threshold_flag_bank`

## Requirements
- R1: During and after reset, every flag is 0 and every lane's run counter is empty.
- R2: With direction bit 1 (over), a sample qualifies when it is greater than or equal to the lane threshold, so a sample equal to the threshold qualifies.
- R3: With direction bit 0 (under), a sample qualifies when it is strictly less than the lane threshold, so a sample equal to the threshold does not qualify.
- R4: A low flag goes to 1 at the clock edge that captures the N-th consecutive qualifying valid sample, where N is the rise count. A valid non-qualifying sample before that restarts the run.
- R5: A high flag goes to 0 at the edge that captures the M-th consecutive non-qualifying valid sample, where M is the fall count. A qualifying valid sample before that restarts the run. The run starts fresh at the sample after each flag change.
- R6: A count of 1 makes the flag follow the comparison on each valid sample. A count of 0 behaves as 1.
- R7: Cycles with the sample strobe low leave every flag and run counter unchanged.
- R8: Lanes are independent, and a change to a lane's configuration applies from the next valid sample on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld_i | input | 1 | Sample strobe |
| smp_val_i | input | SMP_W | Filtered sample value (unsigned) |
| thr_i | input | LANES*SMP_W | Per-lane threshold, lane k at bits [k*SMP_W +: SMP_W] |
| over_i | input | LANES | Per-lane direction: 1 over, 0 under |
| rise_cnt_i | input | LANES*8 | Per-lane rise run length |
| fall_cnt_i | input | LANES*8 | Per-lane fall run length |
| flag_o | output | LANES | Registered debounced flags |

## Verification
Two events can land on the same valid sample: the run counter reaching its target, and the comparison reversing. When both occur, the flag toggles and the counter must restart in the same edge. The bench provokes this with bursts one sample short of the rise count, followed by a failing sample, and then by a run of exactly the rise count whose last sample equals the threshold. The flag must stay low through the short burst and rise on the exact capturing edge. A second event pair is an idle strobe arriving mid-run, which must neither advance the count nor reset it. The bench judges this by the edge on which the flag finally changes.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
  localparam int CNT_W = 8;

  typedef enum logic {
    DIR_UNDER = 1'b0,
    DIR_OVER  = 1'b1
  } dir_e;

  // A programmed run length of zero acts as one.
  function automatic logic [CNT_W-1:0] eff_len(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  // True when a run of cur+1 samples reaches the target length.
  function automatic logic run_done(input logic [CNT_W-1:0] cur,
                                    input logic [CNT_W-1:0] tgt);
    return ({1'b0, cur} + 1'b1) >= {1'b0, tgt};
  endfunction
endpackage

// File: rtl/thr_compare.sv
module thr_compare #(
  parameter int SMP_W = 12
) (
  input  logic [SMP_W-1:0] val_i,
  input  logic [SMP_W-1:0] thr_i,
  input  logic             over_i,
  output logic             qual_o
);
  import tflag_pkg::*;

  always_comb begin
    if (dir_e'(over_i) == DIR_OVER) qual_o = (val_i >= thr_i);
    else                            qual_o = (val_i <  thr_i);
  end
endmodule

// File: rtl/run_debounce.sv
module run_debounce
  import tflag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic             qual_i,
  input  logic [CNT_W-1:0] rise_cnt_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] run_q;
  logic [CNT_W-1:0] tgt;
  logic             extend;   // sample continues the run toward a toggle
  logic             reach;    // run hits its target on this sample

  assign tgt    = flag_o ? eff_len(fall_cnt_i) : eff_len(rise_cnt_i);
  assign extend = flag_o ? !qual_i : qual_i;
  assign reach  = extend && run_done(run_q, tgt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      run_q  <= '0;
    end else if (vld_i) begin
      if (!extend) begin
        run_q <= '0;
      end else if (reach) begin
        flag_o <= !flag_o;
        run_q  <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(flag_o) && $stable(run_q)));
  p_rise_needs_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> ($past(vld_i) && $past(qual_i)));
  p_fall_needs_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> ($past(vld_i) && !$past(qual_i)));
  p_unit_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && qual_i && !flag_o && rise_cnt_i <= CNT_W'(1)) |=> flag_o);
  p_unit_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !qual_i && flag_o && fall_cnt_i <= CNT_W'(1)) |=> !flag_o);
  p_fresh_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o != $past(flag_o)) |-> (run_q == '0));
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q != '1);
endmodule

// File: rtl/flag_lane.sv
module flag_lane
  import tflag_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [SMP_W-1:0] val_i,
  input  logic [SMP_W-1:0] thr_i,
  input  logic             over_i,
  input  logic [CNT_W-1:0] rise_cnt_i,
  input  logic [CNT_W-1:0] fall_cnt_i,
  output logic             flag_o
);
  logic qual;

  thr_compare #(.SMP_W(SMP_W)) u_cmp (
    .val_i (val_i),
    .thr_i (thr_i),
    .over_i(over_i),
    .qual_o(qual)
  );

  run_debounce u_deb (
    .clk       (clk),
    .rst_n     (rst_n),
    .vld_i     (vld_i),
    .qual_i    (qual),
    .rise_cnt_i(rise_cnt_i),
    .fall_cnt_i(fall_cnt_i),
    .flag_o    (flag_o)
  );

  p_over_eq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (over_i && val_i == thr_i) |-> qual);
  p_under_eq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!over_i && val_i == thr_i) |-> !qual);
endmodule

// File: rtl/threshold_flag_bank.sv
module threshold_flag_bank
  import tflag_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   smp_vld_i,
  input  logic [SMP_W-1:0]       smp_val_i,
  input  logic [LANES*SMP_W-1:0] thr_i,
  input  logic [LANES-1:0]       over_i,
  input  logic [LANES*CNT_W-1:0] rise_cnt_i,
  input  logic [LANES*CNT_W-1:0] fall_cnt_i,
  output logic [LANES-1:0]       flag_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    flag_lane #(.SMP_W(SMP_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (smp_vld_i),
      .val_i     (smp_val_i),
      .thr_i     (thr_i[k*SMP_W +: SMP_W]),
      .over_i    (over_i[k]),
      .rise_cnt_i(rise_cnt_i[k*CNT_W +: CNT_W]),
      .fall_cnt_i(fall_cnt_i[k*CNT_W +: CNT_W]),
      .flag_o    (flag_o[k])
    );
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (flag_o == '0));
endmodule

// File: tb/tb_threshold_flag_bank.sv
module tb_threshold_flag_bank;
  localparam int SMP_W = 12;
  localparam int LANES = 2;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 vld;
  logic [SMP_W-1:0]     val;
  logic [LANES*SMP_W-1:0] thr;
  logic [LANES-1:0]     over;
  logic [LANES*8-1:0]   rise_c, fall_c;
  logic [LANES-1:0]     flag;

  int checks = 0;
  int errors = 0;
  logic exp1;

  always #4 clk = ~clk;

  threshold_flag_bank #(.SMP_W(SMP_W), .LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_val_i(val),
    .thr_i(thr), .over_i(over), .rise_cnt_i(rise_c), .fall_cnt_i(fall_c),
    .flag_o(flag)
  );

  // {strobe, sample, expected lane-0 flag}; lane 0: over, thr 100, rise 3, fall 2
  localparam logic [13:0] VEC [13] = '{
    {1'b1, 12'd100, 1'b0}, {1'b1, 12'd120, 1'b0}, {1'b1, 12'd50,  1'b0},
    {1'b1, 12'd101, 1'b0}, {1'b0, 12'd0,   1'b0}, {1'b1, 12'd150, 1'b0},
    {1'b1, 12'd100, 1'b1}, {1'b1, 12'd10,  1'b1}, {1'b1, 12'd200, 1'b1},
    {1'b1, 12'd10,  1'b1}, {1'b0, 12'd10,  1'b1}, {1'b1, 12'd99,  1'b0},
    {1'b1, 12'd100, 1'b0}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [SMP_W-1:0] s);
    @(negedge clk);
    vld = v;
    val = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; val = '0;
    thr = {12'd100, 12'd100};
    over = 2'b01;                      // lane 1 under, lane 0 over
    rise_c = {8'd1, 8'd3};
    fall_c = {8'd1, 8'd2};
    repeat (3) @(posedge clk);
    #1;
    check("R1 lane0", flag[0], 1'b0);
    check("R1 lane1", flag[1], 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: lane 0 debounced (R2 R4 R5 R7), lane 1 pass-through under (R3 R6 R8)
    exp1 = 1'b0;
    for (int i = 0; i < 13; i++) begin
      step(VEC[i][13], VEC[i][12:1]);
      if (VEC[i][13]) exp1 = (VEC[i][12:1] < 12'd100);
      check("R4/R5 table lane0", flag[0], VEC[i][0]);
      check("R6/R8 table lane1", flag[1], exp1);
    end

    // R3: under with sample equal to threshold does not qualify
    step(1'b1, 12'd100);
    check("R3 equal not under", flag[1], 1'b0);

    // R6: count of 0 behaves as 1 on lane 0
    rise_c[7:0] = 8'd0;
    fall_c[7:0] = 8'd0;
    step(1'b1, 12'd300);
    check("R6 zero rise", flag[0], 1'b1);
    step(1'b1, 12'd5);
    check("R6 zero fall", flag[0], 1'b0);

    // R8: new config at next valid sample; longer rise run of 4
    rise_c[7:0] = 8'd4;
    fall_c[7:0] = 8'd3;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 12'd100);
      check("R8 rise run short", flag[0], 1'b0);
    end
    step(1'b0, 12'd0);
    check("R7 idle mid-run", flag[0], 1'b0);
    step(1'b1, 12'd100);
    check("R2/R4 rise at 4th", flag[0], 1'b1);
    // R5: fall needs 3 fails; qualifying sample restarts
    step(1'b1, 12'd1);
    step(1'b1, 12'd1);
    check("R5 two fails held", flag[0], 1'b1);
    step(1'b1, 12'd100);
    step(1'b1, 12'd1);
    step(1'b1, 12'd1);
    check("R5 restart held", flag[0], 1'b1);
    step(1'b1, 12'd1);
    check("R5 fall at 3rd", flag[0], 1'b0);

    // R1: reset mid-operation clears the flag
    step(1'b1, 12'd2);
    check("R6 lane1 high", flag[1], 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check("R1 reset clears", flag[1], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule